// File: doc/BRIEF.md
# Brown-out Step Dimming Controller

This block holds a four-level LED current setpoint for a mains-powered driver and lowers it one level each time the line is briefly interrupted. A digital comparator flag reports that the line-sense voltage has fallen below its off threshold. When that flag stays set for a full blanking window, the event counts as a qualified brown-out. The setpoint then moves to the next lower level, and from the lowest level it returns to full current. Switching stays stopped until a second flag reports that the line-sense voltage has risen above the higher on threshold.

Two mechanisms return the setpoint to full current. The first is a brown-out fault that stays active for longer than the step-reset window. The second is the supply falling below its reset level. If the supply drops below its minimum operating level before a brown-out is qualified, the pending event is discarded and the level is kept. Both windows are counters whose lengths are derived from a clock-frequency parameter.

Top module: `stepdim_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, `step_idx` is 0, `pct_code` is 0, `bo_fault` is 0 and `sw_en` is 0.
- R2: Each qualified brown-out moves `step_idx` through 0, 1, 2, 3 and then back to 0. `pct_code` encodes the setpoint as 0 for 100 %, 1 for 70 %, 2 for 25 % and 3 for 5 %, and follows `step_idx` at the same edge.
- R3: A brown-out is qualified at the BLANK_CYC-th consecutive edge at which `line_low` and `supply_ok` are both high and no fault is active. At that edge `bo_fault` rises and the step advances. If `line_low` drops before that edge, the blanking count restarts from zero.
- R4: Once set, `bo_fault` stays high and `sw_en` stays low until an edge samples `line_high` high. That edge clears `bo_fault`.
- R5: A qualified brown-out advances the step only once. Holding `line_low` high after qualification causes no further advance until the fault has been cleared.
- R6: If `bo_fault` remains set for RESET_CYC edges after qualification, `step_idx` and `pct_code` return to 0 at that edge. `bo_fault` stays set.
- R7: An edge that samples `supply_rst` high clears `step_idx`, `pct_code` and `bo_fault` to 0.
- R8: An edge that samples `supply_ok` low while no fault is active restarts the blanking count and leaves `step_idx` unchanged.
- R9: `sw_en` is registered. It is high after an edge exactly when that edge samples `supply_ok` high and `bo_fault` is low after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_low | input | 1 | Line-sense voltage below the off threshold |
| line_high | input | 1 | Line-sense voltage above the on threshold |
| supply_ok | input | 1 | Supply above its minimum operating level |
| supply_rst | input | 1 | Supply below its reset level |
| step_idx | output | 2 | Current dimming step, 0 = full |
| pct_code | output | 2 | Setpoint code: 0 = 100 %, 1 = 70 %, 2 = 25 %, 3 = 5 % |
| bo_fault | output | 1 | Qualified brown-out active |
| sw_en | output | 1 | Switching permitted |

## Verification
The bench builds the block with CLK_HZ = 1000, which makes the blanking window 25 cycles and the step-reset window 3000 cycles. At this scale the bench can drive a complete wrap through all four levels and reach the long-brown-out reset. It can also land one cycle on either side of both window boundaries, with several of these runs in a single short simulation. The bench also cuts a blanking window short, both by a one-cycle drop of the line flag and by a supply loss, and observes that the count restarts.

// File: rtl/stepdim_pkg.sv
package stepdim_pkg;

  typedef enum logic [1:0] {
    PCT_100 = 2'd0,
    PCT_70  = 2'd1,
    PCT_25  = 2'd2,
    PCT_5   = 2'd3
  } pct_e;

  function automatic pct_e pct_of(input logic [1:0] step);
    case (step)
      2'd0:    return PCT_100;
      2'd1:    return PCT_70;
      2'd2:    return PCT_25;
      default: return PCT_5;
    endcase
  endfunction

endpackage

// File: rtl/stepdim_blank.sv
module stepdim_blank #(
  parameter int unsigned CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic line_low_i,
  input  logic supply_ok_i,
  input  logic armed_i,
  output logic qual_o
);
  localparam int unsigned W = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt_q;
  logic         run;

  assign run    = line_low_i && supply_ok_i && armed_i;
  assign qual_o = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || qual_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  AST_QUAL_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> $past(line_low_i) && $past(supply_ok_i)); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R3

endmodule

// File: rtl/stepdim_hold.sv
module stepdim_hold #(
  parameter int unsigned CYC = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned W = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  AST_HOLD_SATURATES: assert property (@(posedge clk) disable iff (rst)
    expire_o && run_i |=> !run_i || expire_o); // R6

endmodule

// File: rtl/stepdim_state.sv
module stepdim_state
  import stepdim_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       qual_i,
  input  logic       expire_i,
  input  logic       recover_i,
  input  logic       supply_ok_i,
  output logic [1:0] step_o,
  output pct_e       pct_o,
  output logic       fault_o,
  output logic       sw_en_o
);
  logic [1:0] step_d;
  logic       fault_d;

  always_comb begin
    step_d  = step_o;
    fault_d = fault_o;
    if (clr_i) begin
      step_d  = 2'd0;
      fault_d = 1'b0;
    end else if (qual_i) begin
      step_d  = step_o + 2'd1;
      fault_d = 1'b1;
    end else begin
      if (expire_i)             step_d  = 2'd0;
      if (fault_o && recover_i) fault_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_o  <= 2'd0;
      pct_o   <= PCT_100;
      fault_o <= 1'b0;
      sw_en_o <= 1'b0;
    end else begin
      step_o  <= step_d;
      pct_o   <= pct_of(step_d);
      fault_o <= fault_d;
      sw_en_o <= supply_ok_i && !fault_d;
    end
  end

  AST_ONE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    qual_i && !clr_i |=> step_o == 2'($past(step_o) + 2'd1)); // R2

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fault_o && !recover_i && !clr_i |=> fault_o); // R4

endmodule

// File: rtl/stepdim_ctrl.sv
module stepdim_ctrl
  import stepdim_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned BLANK_MS    = 25,
  parameter int unsigned STEP_RST_MS = 3000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_low,
  input  logic       line_high,
  input  logic       supply_ok,
  input  logic       supply_rst,
  output logic [1:0] step_idx,
  output logic [1:0] pct_code,
  output logic       bo_fault,
  output logic       sw_en
);
  localparam int unsigned TICKS_MS  = CLK_HZ / 1000;
  localparam int unsigned BLANK_CYC = TICKS_MS * BLANK_MS;
  localparam int unsigned RESET_CYC = TICKS_MS * STEP_RST_MS;

  logic qual;
  logic expire;
  pct_e pct;

  stepdim_blank #(.CYC(BLANK_CYC)) u_blank (
    .clk         (clk),
    .rst         (rst),
    .line_low_i  (line_low),
    .supply_ok_i (supply_ok),
    .armed_i     (!bo_fault),
    .qual_o      (qual)
  );

  stepdim_hold #(.CYC(RESET_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .run_i    (bo_fault),
    .expire_o (expire)
  );

  stepdim_state u_state (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (supply_rst),
    .qual_i      (qual),
    .expire_i    (expire),
    .recover_i   (line_high),
    .supply_ok_i (supply_ok),
    .step_o      (step_idx),
    .pct_o       (pct),
    .fault_o     (bo_fault),
    .sw_en_o     (sw_en)
  );

  assign pct_code = pct;

  AST_NO_SWITCH_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
    bo_fault |-> !sw_en); // R4

  AST_SUPPLY_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    supply_rst |=> step_idx == 2'd0 && !bo_fault); // R7

  AST_SUPPLY_LOSS_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !supply_ok && !bo_fault && !supply_rst |=> $stable(step_idx)); // R8

  AST_PCT_TRACKS_STEP: assert property (@(posedge clk) disable iff (rst)
    pct_code == step_idx); // R2

endmodule

// File: tb/stepdim_ctrl_tb.sv
module stepdim_ctrl_tb;
  localparam int unsigned BLANK = 25;
  localparam int unsigned HOLD  = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_low = 1'b0, line_high = 1'b0, supply_ok = 1'b1, supply_rst = 1'b0;
  logic [1:0] step_idx, pct_code;
  logic bo_fault, sw_en;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  stepdim_ctrl #(.CLK_HZ(1000), .BLANK_MS(25), .STEP_RST_MS(3000)) u_dut (
    .clk(clk), .rst(rst), .line_low(line_low), .line_high(line_high),
    .supply_ok(supply_ok), .supply_rst(supply_rst),
    .step_idx(step_idx), .pct_code(pct_code), .bo_fault(bo_fault), .sw_en(sw_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] st, input logic fl, input logic sw);
    checks++;
    if (step_idx !== st || pct_code !== st || bo_fault !== fl || sw_en !== sw) begin
      fails++;
      $display("FAIL %s: step=%0d pct=%0d fault=%0b sw=%0b expected step=%0d pct=%0d fault=%0b sw=%0b",
               req, step_idx, pct_code, bo_fault, sw_en, st, st, fl, sw);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Full brown-out event: qualify, then recover; exp is the step after advance
  task automatic event_cycle(input string req, input logic [1:0] exp);
    line_low = 1'b1;
    tick(BLANK - 1);
    check(req, exp - 2'd1, 1'b0, 1'b1);
    tick(1);
    check(req, exp, 1'b1, 1'b0);
    line_low = 1'b0; line_high = 1'b1;
    tick(1);
    check(req, exp, 1'b0, 1'b1);
    line_high = 1'b0;
  endtask

  task automatic t_reset;
    tick(1);
    check("R1", 2'd0, 1'b0, 1'b0);
    rst = 1'b0;
    tick(1);
    check("R9", 2'd0, 1'b0, 1'b1);
  endtask

  task automatic t_wrap;
    event_cycle("R2", 2'd1);
    event_cycle("R2", 2'd2);
    event_cycle("R2", 2'd3);
    event_cycle("R2", 2'd0);
  endtask

  task automatic t_short_pulse;
    line_low = 1'b1; tick(BLANK - 1);
    line_low = 1'b0; tick(1);
    line_low = 1'b1; tick(BLANK - 1);
    check("R3", 2'd0, 1'b0, 1'b1);
    tick(1);
    check("R3", 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_single_advance;
    tick(50);
    check("R5", 2'd1, 1'b1, 1'b0);
    line_low = 1'b0; tick(5);
    check("R4", 2'd1, 1'b1, 1'b0);
    line_high = 1'b1; tick(1);
    check("R4", 2'd1, 1'b0, 1'b1);
    line_high = 1'b0;
  endtask

  task automatic t_long_brownout;
    line_low = 1'b1; tick(BLANK);
    check("R6", 2'd2, 1'b1, 1'b0);
    tick(HOLD - 1);
    check("R6", 2'd2, 1'b1, 1'b0);
    tick(1);
    check("R6", 2'd0, 1'b1, 1'b0);
    line_low = 1'b0; line_high = 1'b1; tick(1);
    check("R4", 2'd0, 1'b0, 1'b1);
    line_high = 1'b0;
  endtask

  task automatic t_supply_loss;
    event_cycle("R8", 2'd1);
    line_low = 1'b1; tick(10);
    supply_ok = 1'b0; tick(1);
    check("R9", 2'd1, 1'b0, 1'b0);
    tick(20);
    check("R8", 2'd1, 1'b0, 1'b0);
    supply_ok = 1'b1; tick(BLANK - 1);
    check("R8", 2'd1, 1'b0, 1'b1);
    tick(1);
    check("R8", 2'd2, 1'b1, 1'b0);
  endtask

  task automatic t_supply_reset;
    supply_rst = 1'b1; tick(1);
    check("R7", 2'd0, 1'b0, 1'b1);
    supply_rst = 1'b0; line_low = 1'b0; tick(1);
    check("R7", 2'd0, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_short_pulse();
    t_single_advance();
    t_long_brownout();
    t_supply_loss();
    t_supply_reset();
    report();
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

endmodule